// File: doc/BRIEF.md
# Relay Output Register File

This block is the register set that sits behind a bus slave in a relay output card. A bus front end has already accepted a transfer and latched its word address, direction, byte-lane enables and write data; this block decodes the access one byte lane at a time and serves 8-, 16- and 32-bit transfers alike. It stores the relay command bits, one per channel, and drives them out as a 64-bit vector. A 16-bit control word holds the fail-lamp bit and the two half-board driver enables. The block also returns a constant identity byte and routes the sensed state of each relay's second contact back to the bus.

Each byte address has a fixed byte lane: the byte at offset N travels on lane 3 − (N mod 4), where lane 3 is D31..D24 and lane 0 is D7..D0. A read result comes back one clock after the request, together with a per-lane flag that says which bytes were really driven. Bytes that nothing drives read as all ones, and the bus side must ignore them. Writes to read-only or empty locations complete normally but leave no trace. Setting the parameter `NUM_CH` to 32 builds the half-size card: channels 32..63 then have no storage and no contact path.

Top module: `relay_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, all 16 control-word bits and all relay command bits go to zero. After that edge `fail_led_on` is 1, `drv_en_lo` and `drv_en_hi` are 0 and `relay_cmd` is all zeros.
- R2: A read of word 0 returns the identity byte 0x1B on lane 3 with its drive flag set. Lane 2, which is byte offset 1, is not driven.
- R3: The control word has its high byte at offset 2 (lane 1 of word 0) and its low byte at offset 3 (lane 0). All 16 bits are stored and read back. `fail_led_on` is the inverse of bit 15. `drv_en_lo` equals bit 14 and covers channels 0..31. `drv_en_hi` equals bit 13 and covers channels 32..63.
- R4: Control byte k (k = 0..7) is at offset 0x10+k, which is word 4 + k/4 on lane 3 − (k mod 4). It holds channels 63−8k down to 56−8k, with the MSB being the highest channel. It drives `relay_cmd[63−8k:56−8k]` and reads back exactly what was written.
- R5: A write loads only the lanes whose `acc_lane_en` bit is set. A read drives only requested lanes. Byte, half-word and word transfers all follow this rule.
- R6: Contact byte k is at offset 0x18+k (word 6 + k/4, lane 3 − (k mod 4)). It returns `contact_sense` in the same channel order as the control bytes, sampled at the clock edge of the request.
- R7: Writes to the identity byte, to the contact bytes and to the empty offsets 0x01 and 0x04..0x0F change neither any output nor any value read back later.
- R8: The empty offsets 0x01 and 0x04..0x0F return a cleared drive flag and the data byte 0xFF.
- R9: With `NUM_CH` = 32, offsets 0x10..0x13 and 0x18..0x1B behave like empty offsets: writes are lost, reads are undriven, and `relay_cmd[63:32]` stays zero.
- R10: `rd_valid` is high exactly in the cycle after an accepted read. In every other cycle `rd_data` is all ones and `rd_lane_drv` is zero.
- R11: A cycle with `acc_valid` low changes nothing, whatever the other access inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| acc_valid | input | 1 | A latched access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 3 | Byte offset divided by four (offset bits 4..2) |
| acc_lane_en | input | 4 | Byte-lane enables, bit 3 = D31..D24 |
| acc_wdata | input | 32 | Write data |
| contact_sense | input | 64 | Sensed second-contact state, bit n = channel n |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read data, undriven lanes all ones |
| rd_lane_drv | output | 4 | Lanes actually driven by the read |
| relay_cmd | output | 64 | Relay command, bit n = channel n |
| drv_en_lo | output | 1 | Driver enable, channels 0..31 |
| drv_en_hi | output | 1 | Driver enable, channels 32..63 |
| fail_led_on | output | 1 | Fail lamp lit |

## Verification
State errors in this block have no hidden delay. A wrong command byte, a misrouted lane, or a corrupted control-word bit shows on `relay_cmd` or on the enable and lamp pins at the very next clock edge. A stored byte that has been corrupted, a write that should have been discarded but landed, or a wrong lane mapping shows up on the next readback of that byte. The bench therefore compares every output in every cycle and reads back every affected word after each stimulus. Contact routing is checked with asymmetric patterns, so that a swapped byte or reversed bit order cannot match.

// File: rtl/relay_regfile_pkg.sv
// Shared constants and types for the relay output register file.
// Assumes a 32-bit data path with four byte lanes and 64 mapped channels.
package relay_regfile_pkg;

    localparam int MAP_CH     = 64;
    localparam int BYTE_W     = 8;
    localparam int LANES      = 4;
    localparam int DATA_W     = LANES * BYTE_W;
    localparam int WORD_W     = 3;
    localparam int CTRL_BYTES = MAP_CH / BYTE_W;
    localparam int IDX_W      = $clog2(CTRL_BYTES);
    localparam int CSR_W      = 16;

    localparam logic [BYTE_W-1:0] ID_BYTE = 8'h1B;

    // functional control-word bits
    localparam int CSR_LAMP_OFF_BIT = 15;
    localparam int CSR_EN_LO_BIT    = 14;
    localparam int CSR_EN_HI_BIT    = 13;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_ID,
        RGN_CSR_HI,
        RGN_CSR_LO,
        RGN_CTRL,
        RGN_CONT
    } rgn_e;

    typedef struct packed {
        rgn_e             rgn;
        logic [IDX_W-1:0] idx;
    } lane_sel_t;

endpackage

// File: rtl/rr_decode.sv
// Per-lane address decoder.
// Turns the word address into one region selection per byte lane; the byte
// at offset N rides on lane 3 - (N mod 4). Bytes of channels absent from a
// reduced build decode as empty. Purely combinational.
module rr_decode
    import relay_regfile_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic [WORD_W-1:0]          word,
    output lane_sel_t [LANES-1:0]      sel
);

    localparam int ABSENT = (MAP_CH - NUM_CH) / BYTE_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [1:0] LPOS = 2'(LANES - 1 - l);
        logic [WORD_W+1:0] off;

        // classify the byte offset carried by this lane
        always_comb begin
            off        = {word, LPOS};
            sel[l].rgn = RGN_NONE;
            sel[l].idx = off[IDX_W-1:0];
            if (off == 5'h00) begin
                sel[l].rgn = RGN_ID;
            end else if (off == 5'h02) begin
                sel[l].rgn = RGN_CSR_HI;
            end else if (off == 5'h03) begin
                sel[l].rgn = RGN_CSR_LO;
            end else if (off[4] && (int'(off[IDX_W-1:0]) >= ABSENT)) begin
                sel[l].rgn = off[3] ? RGN_CONT : RGN_CTRL;
            end
        end
    end

endmodule

// File: rtl/rr_csr.sv
// 16-bit control word, written one byte at a time.
// All bits are stored; reset clears every bit, which lights the lamp and
// disables both driver halves.
module rr_csr
    import relay_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_hi,
    input  logic              we_lo,
    input  logic [BYTE_W-1:0] wd_hi,
    input  logic [BYTE_W-1:0] wd_lo,
    output logic [CSR_W-1:0]  csr_q
);

    // load the enabled halves, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q <= '0;
        end else begin
            if (we_hi) csr_q[CSR_W-1:BYTE_W] <= wd_hi;
            if (we_lo) csr_q[BYTE_W-1:0]     <= wd_lo;
        end
    end

endmodule

// File: rtl/rr_ctrl_bank.sv
// Relay command storage: one byte register per group of eight channels.
// Byte k holds channels 63-8k..56-8k. Bytes outside NUM_CH are not built
// and read as zero.
module rr_ctrl_bank
    import relay_regfile_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [CTRL_BYTES-1:0]               we,
    input  logic [CTRL_BYTES-1:0][BYTE_W-1:0]   wd,
    output logic [MAP_CH-1:0]                   cmd
);

    localparam int ABSENT = (MAP_CH - NUM_CH) / BYTE_W;

    for (genvar k = 0; k < CTRL_BYTES; k++) begin : g_byte
        localparam int LSB = (CTRL_BYTES - 1 - k) * BYTE_W;
        if (k >= ABSENT) begin : g_present
            logic [BYTE_W-1:0] q;
            // hold the command byte for this channel group
            always_ff @(posedge clk) begin
                if (!rst_n)     q <= '0;
                else if (we[k]) q <= wd[k];
            end
            assign cmd[LSB +: BYTE_W] = q;
        end else begin : g_absent
            assign cmd[LSB +: BYTE_W] = '0;
        end
    end

endmodule

// File: rtl/rr_read_mux.sv
// Read data steering: picks the byte for each lane from the identity
// constant, the control word, the command bytes or the contact inputs.
// Lanes that are not requested or that decode as empty are not driven and
// carry all ones. Purely combinational.
module rr_read_mux
    import relay_regfile_pkg::*;
(
    input  lane_sel_t [LANES-1:0]  sel,
    input  logic [LANES-1:0]       lane_en,
    input  logic [CSR_W-1:0]       csr_q,
    input  logic [MAP_CH-1:0]      cmd,
    input  logic [MAP_CH-1:0]      contact,
    output logic [DATA_W-1:0]      data,
    output logic [LANES-1:0]       drv
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        int pos;
        // choose the byte for this lane
        always_comb begin
            pos = (CTRL_BYTES - 1 - int'(sel[l].idx)) * BYTE_W;
            drv[l]                 = lane_en[l] && (sel[l].rgn != RGN_NONE);
            data[l*BYTE_W +: BYTE_W] = '1;
            if (lane_en[l]) begin
                case (sel[l].rgn)
                    RGN_ID:     data[l*BYTE_W +: BYTE_W] = ID_BYTE;
                    RGN_CSR_HI: data[l*BYTE_W +: BYTE_W] = csr_q[CSR_W-1:BYTE_W];
                    RGN_CSR_LO: data[l*BYTE_W +: BYTE_W] = csr_q[BYTE_W-1:0];
                    RGN_CTRL:   data[l*BYTE_W +: BYTE_W] = cmd[pos +: BYTE_W];
                    RGN_CONT:   data[l*BYTE_W +: BYTE_W] = contact[pos +: BYTE_W];
                    default:    data[l*BYTE_W +: BYTE_W] = '1;
                endcase
            end
        end
    end

endmodule

// File: rtl/relay_regfile.sv
// Relay output register file (top).
// Serves latched byte-lane accesses from a bus front end: identity byte,
// 16-bit control word, eight relay command bytes and eight contact bytes.
// Assumes the front end presents one access per acc_valid cycle and owns
// the handshake. Reads return one clock later with a per-lane drive mask.
module relay_regfile
    import relay_regfile_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [2:0]          acc_word,
    input  logic [3:0]          acc_lane_en,
    input  logic [31:0]         acc_wdata,
    input  logic [63:0]         contact_sense,
    output logic                rd_valid,
    output logic [31:0]         rd_data,
    output logic [3:0]          rd_lane_drv,
    output logic [63:0]         relay_cmd,
    output logic                drv_en_lo,
    output logic                drv_en_hi,
    output logic                fail_led_on
);

    lane_sel_t [LANES-1:0]              lane_sel;
    logic                               csr_we_hi, csr_we_lo;
    logic [BYTE_W-1:0]                  csr_wd_hi, csr_wd_lo;
    logic [CSR_W-1:0]                   csr_q;
    logic [CTRL_BYTES-1:0]              ctrl_we;
    logic [CTRL_BYTES-1:0][BYTE_W-1:0]  ctrl_wd;
    logic [DATA_W-1:0]                  rd_next;
    logic [LANES-1:0]                   drv_next;

    rr_decode #(.NUM_CH(NUM_CH)) u_dec (
        .word (acc_word),
        .sel  (lane_sel)
    );

    // route each enabled write lane to its storage target
    always_comb begin
        csr_we_hi = 1'b0;
        csr_we_lo = 1'b0;
        csr_wd_hi = '0;
        csr_wd_lo = '0;
        ctrl_we   = '0;
        ctrl_wd   = '0;
        for (int l = 0; l < LANES; l++) begin
            if (acc_valid && acc_write && acc_lane_en[l]) begin
                case (lane_sel[l].rgn)
                    RGN_CSR_HI: begin
                        csr_we_hi = 1'b1;
                        csr_wd_hi = acc_wdata[l*BYTE_W +: BYTE_W];
                    end
                    RGN_CSR_LO: begin
                        csr_we_lo = 1'b1;
                        csr_wd_lo = acc_wdata[l*BYTE_W +: BYTE_W];
                    end
                    RGN_CTRL: begin
                        ctrl_we[lane_sel[l].idx] = 1'b1;
                        ctrl_wd[lane_sel[l].idx] = acc_wdata[l*BYTE_W +: BYTE_W];
                    end
                    default: ;
                endcase
            end
        end
    end

    rr_csr u_csr (
        .clk   (clk),
        .rst_n (rst_n),
        .we_hi (csr_we_hi),
        .we_lo (csr_we_lo),
        .wd_hi (csr_wd_hi),
        .wd_lo (csr_wd_lo),
        .csr_q (csr_q)
    );

    rr_ctrl_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl_we),
        .wd    (ctrl_wd),
        .cmd   (relay_cmd)
    );

    rr_read_mux u_rmux (
        .sel     (lane_sel),
        .lane_en (acc_lane_en),
        .csr_q   (csr_q),
        .cmd     (relay_cmd),
        .contact (contact_sense),
        .data    (rd_next),
        .drv     (drv_next)
    );

    // register the read result for one cycle, idle value otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid    <= 1'b0;
            rd_data     <= '1;
            rd_lane_drv <= '0;
        end else if (acc_valid && !acc_write) begin
            rd_valid    <= 1'b1;
            rd_data     <= rd_next;
            rd_lane_drv <= drv_next;
        end else begin
            rd_valid    <= 1'b0;
            rd_data     <= '1;
            rd_lane_drv <= '0;
        end
    end

    assign fail_led_on = ~csr_q[CSR_LAMP_OFF_BIT];
    assign drv_en_lo   = csr_q[CSR_EN_LO_BIT];
    assign drv_en_hi   = csr_q[CSR_EN_HI_BIT];

endmodule

// File: rtl/relay_regfile_chk.sv
// Port-level property checker for relay_regfile, attached by bind.
module relay_regfile_chk #(
    parameter int NUM_CH = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [3:0]  acc_lane_en,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic [3:0]  rd_lane_drv,
    input logic [63:0] relay_cmd,
    input logic        drv_en_lo,
    input logic        drv_en_hi,
    input logic        fail_led_on
);

    logic [31:0] drv_mask;
    assign drv_mask = {{8{rd_lane_drv[3]}}, {8{rd_lane_drv[2]}},
                       {8{rd_lane_drv[1]}}, {8{rd_lane_drv[0]}}};

    AST_SAFE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fail_led_on && !drv_en_lo && !drv_en_hi && relay_cmd == '0)); // R1

    AST_CMD_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_valid && acc_write) |-> $stable(relay_cmd)); // R11

    AST_CSR_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_valid && acc_write) |-> ($stable(drv_en_lo) && $stable(drv_en_hi) && $stable(fail_led_on))); // R3

    AST_RD_AFTER_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && !acc_write)); // R10

    AST_RD_LANES_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_lane_drv & ~$past(acc_lane_en)) == 4'b0000)); // R5

    AST_UNDRIVEN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        &(rd_data | drv_mask)); // R8

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_lane_drv == 4'b0000)); // R10

    if (NUM_CH <= 32) begin : g_half
        AST_UPPER_CMD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            relay_cmd[63:32] == '0); // R9
    end

endmodule

bind relay_regfile relay_regfile_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_lane_en (acc_lane_en),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_lane_drv (rd_lane_drv),
    .relay_cmd   (relay_cmd),
    .drv_en_lo   (drv_en_lo),
    .drv_en_hi   (drv_en_hi),
    .fail_led_on (fail_led_on)
);

// File: tb/relay_regfile_test.sv
// Bench: full build (uut) and half build (uut32) share stimulus; a
// behavioural byte-map model predicts every output in every cycle.
module relay_regfile_test;

    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        acc_valid, acc_write;
    logic [2:0]  acc_word;
    logic [3:0]  acc_lane_en;
    logic [31:0] acc_wdata;
    logic [63:0] contact_sense;

    logic        a_rv, b_rv, a_lo, b_lo, a_hi, b_hi, a_led, b_led;
    logic [31:0] a_rd, b_rd;
    logic [3:0]  a_drv, b_drv;
    logic [63:0] a_cmd, b_cmd;

    relay_regfile #(.NUM_CH(64)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_word(acc_word), .acc_lane_en(acc_lane_en), .acc_wdata(acc_wdata),
        .contact_sense(contact_sense), .rd_valid(a_rv), .rd_data(a_rd),
        .rd_lane_drv(a_drv), .relay_cmd(a_cmd), .drv_en_lo(a_lo),
        .drv_en_hi(a_hi), .fail_led_on(a_led));

    relay_regfile #(.NUM_CH(32)) uut32 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_word(acc_word), .acc_lane_en(acc_lane_en), .acc_wdata(acc_wdata),
        .contact_sense(contact_sense), .rd_valid(b_rv), .rd_data(b_rd),
        .rd_lane_drv(b_drv), .relay_cmd(b_cmd), .drv_en_lo(b_lo),
        .drv_en_hi(b_hi), .fail_led_on(b_led));

    int vectors = 0;
    int misses  = 0;

    // model state, index 0 = 64-channel build, 1 = 32-channel build
    logic [63:0] m_cmd [2];
    logic [15:0] m_csr [2];
    logic        e_valid;
    logic [31:0] e_data [2];
    logic [3:0]  e_drv  [2];

    // what byte offset 'off' returns in build v
    function automatic void model_rd(input int v, input int off,
                                     output logic d, output logic [7:0] b);
        int k;
        d = 1'b0;
        b = 8'hFF;
        if (off == 0) begin
            d = 1'b1; b = 8'h1B;
        end else if (off == 2) begin
            d = 1'b1; b = m_csr[v][15:8];
        end else if (off == 3) begin
            d = 1'b1; b = m_csr[v][7:0];
        end else if (off >= 16) begin
            k = off % 8;
            if (v == 0 || k >= 4) begin
                d = 1'b1;
                if (off < 24) b = m_cmd[v][(7 - k) * 8 +: 8];
                else          b = contact_sense[(7 - k) * 8 +: 8];
            end
        end
    endfunction

    // effect of writing byte b to offset 'off' in build v
    function automatic void model_wr(input int v, input int off, input logic [7:0] b);
        int k;
        if (off == 2) m_csr[v][15:8] = b;
        else if (off == 3) m_csr[v][7:0] = b;
        else if (off >= 16 && off < 24) begin
            k = off - 16;
            if (v == 0 || k >= 4) m_cmd[v][(7 - k) * 8 +: 8] = b;
        end
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // compare every output of both builds against the model
    task automatic compare_all(input string tag);
        for (int v = 0; v < 2; v++) begin
            string t;
            logic [31:0] mask, rd;
            t  = (v == 1) ? {"R9 ", tag} : tag;
            rd = v ? b_rd : a_rd;
            mask = 32'h0;
            for (int l = 0; l < 4; l++) if (e_drv[v][l]) mask[l*8 +: 8] = 8'hFF;
            chk(t, "relay_cmd",   v ? b_cmd : a_cmd, m_cmd[v]);
            chk(t, "fail_led_on", {63'd0, v ? b_led : a_led}, {63'd0, ~m_csr[v][15]});
            chk(t, "drv_en_lo",   {63'd0, v ? b_lo : a_lo}, {63'd0, m_csr[v][14]});
            chk(t, "drv_en_hi",   {63'd0, v ? b_hi : a_hi}, {63'd0, m_csr[v][13]});
            chk(t, "rd_valid",    {63'd0, v ? b_rv : a_rv}, {63'd0, e_valid});
            chk(t, "rd_lane_drv", {60'd0, v ? b_drv : a_drv}, {60'd0, e_drv[v]});
            chk(t, "rd_data",     {32'd0, rd & mask}, {32'd0, e_data[v] & mask});
            if (!e_valid) chk(t, "rd_data idle", {32'd0, rd}, {32'd0, 32'hFFFF_FFFF});
        end
        vectors++;
    endtask

    // one bus cycle: drive at negedge, model at posedge, compare at negedge
    task automatic cycle(input string tag, input logic v, input logic w,
                         input logic [2:0] word, input logic [3:0] le,
                         input logic [31:0] wd);
        acc_valid   = v;
        acc_write   = w;
        acc_word    = word;
        acc_lane_en = le;
        acc_wdata   = wd;
        @(posedge clk);
        e_valid = v && !w;
        for (int m = 0; m < 2; m++) begin
            e_drv[m]  = 4'b0;
            e_data[m] = 32'hFFFF_FFFF;
            for (int l = 0; l < 4; l++) begin
                int off;
                logic d;
                logic [7:0] b;
                off = int'(word) * 4 + (3 - l);
                if (v && le[l]) begin
                    if (w) model_wr(m, off, wd[l*8 +: 8]);
                    else begin
                        model_rd(m, off, d, b);
                        e_drv[m][l] = d;
                        if (d) e_data[m][l*8 +: 8] = b;
                    end
                end
            end
        end
        @(negedge clk);
        compare_all(tag);
        acc_valid = 1'b0;
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        acc_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            for (int m = 0; m < 2; m++) begin
                m_cmd[m] = '0; m_csr[m] = '0; e_drv[m] = '0; e_data[m] = '1;
            end
            e_valid = 1'b0;
            @(negedge clk);
            compare_all("R1");
        end
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        misses++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_word = '0;
        acc_lane_en = '0; acc_wdata = '0;
        contact_sense = 64'hC3A5_0F96_1E2D_4B78;
        do_reset(3);

        cycle("R2", 1, 0, 3'd0, 4'b1111, 0);                  // identity + control word
        cycle("R3", 1, 1, 3'd0, 4'b0011, 32'h0000_E0A5);      // 16-bit control write
        cycle("R3", 1, 0, 3'd0, 4'b0011, 0);
        cycle("R5", 1, 1, 3'd0, 4'b0010, 32'h0000_40FF);      // byte write, lane 1 only
        cycle("R3", 1, 0, 3'd0, 4'b1111, 0);
        cycle("R3", 1, 1, 3'd0, 4'b0010, 32'h0000_2000);      // only upper half enabled
        cycle("R3", 1, 1, 3'd0, 4'b0010, 32'h0000_E000);

        cycle("R4", 1, 1, 3'd4, 4'b1111, 32'h8001_FF00);      // channels 63..32
        cycle("R4", 1, 1, 3'd5, 4'b1111, 32'h1234_5678);      // channels 31..0
        cycle("R4", 1, 0, 3'd4, 4'b1111, 0);
        cycle("R4", 1, 0, 3'd5, 4'b1111, 0);
        cycle("R5", 1, 1, 3'd5, 4'b0100, 32'hAAC3_BBCC);      // offset 0x15 only
        cycle("R5", 1, 1, 3'd4, 4'b1100, 32'h5A3C_9999);      // half-word, offsets 0x10/0x11
        cycle("R5", 1, 0, 3'd4, 4'b0101, 0);                  // partial read
        cycle("R5", 1, 0, 3'd5, 4'b1111, 0);
        cycle("R5", 1, 1, 3'd5, 4'b0000, 32'hFFFF_FFFF);      // no lanes

        cycle("R6", 1, 0, 3'd6, 4'b1111, 0);
        cycle("R6", 1, 0, 3'd7, 4'b1111, 0);
        contact_sense = 64'h0102_0408_1020_4080;
        cycle("R6", 1, 0, 3'd6, 4'b1001, 0);
        cycle("R6", 1, 0, 3'd7, 4'b1111, 0);

        cycle("R7", 1, 1, 3'd0, 4'b1100, 32'h0000_0000);      // identity + empty byte
        cycle("R7", 1, 1, 3'd6, 4'b1111, 32'h0000_0000);      // contact bytes
        cycle("R7", 1, 1, 3'd7, 4'b1111, 32'hFFFF_FFFF);
        for (int w = 1; w < 4; w++)
            cycle("R7", 1, 1, 3'(w), 4'b1111, 32'h0000_0000);
        cycle("R7", 1, 0, 3'd0, 4'b1111, 0);
        cycle("R7", 1, 0, 3'd4, 4'b1111, 0);
        cycle("R7", 1, 0, 3'd5, 4'b1111, 0);

        for (int w = 1; w < 4; w++)
            cycle("R8", 1, 0, 3'(w), 4'b1111, 0);

        cycle("R11", 0, 1, 3'd4, 4'b1111, 32'h0000_0000);     // not valid: ignored
        cycle("R11", 0, 1, 3'd0, 4'b1111, 32'h0000_0000);
        cycle("R11", 0, 0, 3'd4, 4'b1111, 0);
        cycle("R10", 1, 0, 3'd4, 4'b1111, 0);
        cycle("R10", 0, 0, 3'd0, 4'b0000, 0);

        for (int i = 0; i < 8; i++) begin
            cycle("R4", 1, 1, 3'(4 + (i % 2)), 4'b1111, 32'h1357_9BDF ^ (32'h0101_0101 << i));
            cycle("R4", 1, 0, 3'(4 + (i % 2)), 4'b1111, 0);
        end

        do_reset(2);
        cycle("R1", 1, 0, 3'd0, 4'b1111, 0);
        cycle("R1", 1, 0, 3'd4, 4'b1111, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule